// File: doc/BRIEF.md
# Periodic Activity Monitor Counter

This block measures how busy a target processor is. It counts the cycles in which the target is active over a window that repeats. The window length is a number of sample ticks. Each sample tick is made by dividing a reference-clock pulse stream by a fixed divisor, and software selects which divisor. Every active cycle adds a programmable weight, scaled by 1/256, into a running accumulator. With the default weight, each active cycle adds exactly one count.

When a window closes, the whole part of the accumulator is copied into a readable count register and the accumulator starts again from zero. An end-of-window status flag is set at the same moment. Software clears that flag by writing a one to it. A level-high interrupt is raised while the flag is set and its enable bit is on. Turning sampling on and off is done through a 32-bit register port.

Both input strobes arrive already synchronized into `clk_i`. Clock-domain crossing, the conversion to a percentage and any bus fabric live outside the block.

Top module: `act_mon_top`

## Requirements
- R1: After reset, every register reads zero except the weight register at 0x24, which reads 0x100, and `irq_o` is low.
- R2: Sampling runs only while both control bits 31 (global enable) and 13 (periodic enable) of the register at 0x00 are set. A window lasts max(P,1) sample ticks, where P is control bits [7:0]. A sample tick is 256 `ref_tick_i` pulses when bit 2 of the register at 0x28 is clear, and 65536 pulses when that bit is set.
- R3: Each cycle with `busy_en_i` high inside a running window adds weight/256 to the accumulator, and 8 fraction bits are kept. The count register at 0x18 reads floor(active_cycles * weight / 256) for the last completed window. The cycle that closes a window is included in that window.
- R4: At each window boundary the count register is reloaded and the accumulator restarts from zero, so consecutive identical windows read the same count.
- R5: The count saturates at 0xFFFFFFFF instead of wrapping.
- R6: Bit 27 of the status register at 0x20 is set at every window boundary, whatever the interrupt enable is. Writing a one to that bit clears it. Writing a zero leaves it unchanged.
- R7: `irq_o` is high exactly while status bit 27 and control bit 15 are both set. It is a level, not a pulse.
- R8: Clearing either enable bit stops all windows. Setting both again starts a fresh window and a fresh accumulator.
- R9: The count register cannot be written. A write to 0x18 leaves its value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference-clock pulse, one cycle per reference period |
| busy_en_i | input | 1 | Target-active qualifier for this cycle |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high together with req_i |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level-high end-of-window interrupt |

## Verification
Two situations are hard to reach from the ports. The first is saturation, because the count needs more than four billion units inside one window. The stimulus gets there by programming the largest weight over a two-tick window, so the accumulator reaches its ceiling within a few hundred cycles. The second is checking exact window lengths and counts while busy and reference pulses are sparse. For that, the bench derives both strobes from a cycle index that restarts at the enabling write, which makes the closing edge and the number of active cycles computable in advance. The bench then confirms them by counting cycles until the interrupt rises.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PER_W  = 8;
  localparam int unsigned FRAC_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_WEIGHT = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_TICK   = 8'h28;

  localparam int unsigned BIT_GLOB = 31;
  localparam int unsigned BIT_IRQ  = 15;
  localparam int unsigned BIT_PER  = 13;
  localparam int unsigned BIT_EOW  = 27;
  localparam int unsigned BIT_SLOW = 2;

  localparam logic [DATA_W-1:0] WEIGHT_RST = 32'h0000_0100;

  typedef struct packed {
    logic             glob_en;
    logic             irq_en;
    logic             per_en;
    logic [PER_W-1:0] period;
  } ctrl_t;
endpackage

// File: rtl/act_mon_regs.sv
module act_mon_regs
  import act_mon_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              win_end_i,
  input  logic [DW-1:0]     snap_i,
  output logic [DW-1:0]     rdata_o,
  output ctrl_t             ctrl_o,
  output logic              slow_o,
  output logic [DW-1:0]     weight_o,
  output logic [DW-1:0]     count_o,
  output logic              eow_o
);
  logic  wr_en;
  logic  wr_ctrl, wr_stat, wr_weight, wr_tick;
  ctrl_t ctrl_q;
  logic  slow_q, eow_q;
  logic [DW-1:0] weight_q, count_q;

  assign wr_en     = req_i & we_i;
  assign wr_ctrl   = wr_en && (addr_i == OFS_CTRL);
  assign wr_stat   = wr_en && (addr_i == OFS_STAT);
  assign wr_weight = wr_en && (addr_i == OFS_WEIGHT);
  assign wr_tick   = wr_en && (addr_i == OFS_TICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      slow_q   <= 1'b0;
      weight_q <= WEIGHT_RST[DW-1:0];
    end else begin
      if (wr_ctrl) begin
        ctrl_q.glob_en <= wdata_i[BIT_GLOB];
        ctrl_q.irq_en  <= wdata_i[BIT_IRQ];
        ctrl_q.per_en  <= wdata_i[BIT_PER];
        ctrl_q.period  <= wdata_i[PER_W-1:0];
      end
      if (wr_tick)   slow_q   <= wdata_i[BIT_SLOW];
      if (wr_weight) weight_q <= wdata_i;
    end
  end

  // boundary set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         eow_q <= 1'b0;
    else if (win_end_i)                  eow_q <= 1'b1;
    else if (wr_stat && wdata_i[BIT_EOW]) eow_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (win_end_i) count_q <= snap_i;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[BIT_GLOB]    = ctrl_q.glob_en;
        rdata_o[BIT_IRQ]     = ctrl_q.irq_en;
        rdata_o[BIT_PER]     = ctrl_q.per_en;
        rdata_o[PER_W-1:0]   = ctrl_q.period;
      end
      OFS_COUNT:  rdata_o = count_q;
      OFS_STAT:   rdata_o[BIT_EOW] = eow_q;
      OFS_WEIGHT: rdata_o = weight_q;
      OFS_TICK:   rdata_o[BIT_SLOW] = slow_q;
      default:    rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign slow_o   = slow_q;
  assign weight_o = weight_q;
  assign count_o  = count_q;
  assign eow_o    = eow_q;
endmodule

// File: rtl/act_mon_window.sv
module act_mon_window #(
  parameter int unsigned FAST_LOG2 = 8,
  parameter int unsigned SLOW_LOG2 = 16,
  parameter int unsigned PER_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ref_tick_i,
  input  logic             slow_i,
  input  logic [PER_W-1:0] period_i,
  output logic             win_end_o
);
  localparam int unsigned PRE_W = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'((1 << FAST_LOG2) - 1);
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'((1 << SLOW_LOG2) - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] win_q;
  logic             pre_last, tick, win_last;

  // >= keeps a fast-mode switch mid-count from waiting for a full wrap
  assign pre_last = slow_i ? (pre_q == SLOW_LAST) : (pre_q >= FAST_LAST);
  assign tick     = run_i & ref_tick_i & pre_last;
  // period 0 behaves as 1
  assign win_last = ({1'b0, win_q} + 1'b1) >= {1'b0, period_i};
  assign win_end_o = tick & win_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      win_q <= '0;
    end else if (!run_i) begin
      pre_q <= '0;
      win_q <= '0;
    end else begin
      if (ref_tick_i) pre_q <= pre_last ? '0 : pre_q + 1'b1;
      if (tick)       win_q <= win_last ? '0 : win_q + 1'b1;
    end
  end
endmodule

// File: rtl/act_mon_accum.sv
module act_mon_accum #(
  parameter int unsigned DW     = 32,
  parameter int unsigned FRAC_W = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          act_i,
  input  logic [DW-1:0] weight_i,
  input  logic          win_end_i,
  output logic [DW-1:0] snap_o,
  output logic [DW-1:0] acc_int_o
);
  localparam int unsigned ACC_W = DW + FRAC_W;

  logic [ACC_W-1:0] acc_q, acc_nxt, acc_sat;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {{(FRAC_W+1){1'b0}}, weight_i};
  assign acc_sat = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  assign acc_nxt = (run_i & act_i) ? acc_sat : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    acc_q <= '0;
    else if (win_end_i || !run_i)   acc_q <= '0;
    else                            acc_q <= acc_nxt;
  end

  assign snap_o    = acc_nxt[ACC_W-1:FRAC_W];
  assign acc_int_o = acc_q[ACC_W-1:FRAC_W];
endmodule

// File: rtl/act_mon_top.sv
module act_mon_top
  import act_mon_pkg::*;
#(
  parameter int unsigned FAST_LOG2 = 8,
  parameter int unsigned SLOW_LOG2 = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              busy_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic              slow, run, win_end, irq_en, eow;
  logic [DATA_W-1:0] weight, snap, count_val, acc_int;

  act_mon_regs #(.DW(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .win_end_i(win_end),
    .snap_i   (snap),
    .rdata_o  (rdata_o),
    .ctrl_o   (ctrl),
    .slow_o   (slow),
    .weight_o (weight),
    .count_o  (count_val),
    .eow_o    (eow)
  );

  assign run    = ctrl.glob_en & ctrl.per_en;
  assign irq_en = ctrl.irq_en;

  act_mon_window #(
    .FAST_LOG2(FAST_LOG2),
    .SLOW_LOG2(SLOW_LOG2),
    .PER_W    (PER_W)
  ) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .ref_tick_i(ref_tick_i),
    .slow_i    (slow),
    .period_i  (ctrl.period),
    .win_end_o (win_end)
  );

  act_mon_accum #(.DW(DATA_W), .FRAC_W(FRAC_W)) u_accum (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .act_i    (busy_en_i),
    .weight_i (weight),
    .win_end_i(win_end),
    .snap_o   (snap),
    .acc_int_o(acc_int)
  );

  assign irq_o = eow & irq_en;
endmodule

// File: rtl/act_mon_chk.sv
module act_mon_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic        win_end_i,
  input logic        irq_en_i,
  input logic        irq_i,
  input logic        eow_i,
  input logic [31:0] count_i,
  input logic [31:0] acc_int_i
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_i); // R7

  AST_NO_WIN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !win_end_i); // R8

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_i) |-> $past(win_end_i)); // R9

  AST_EOW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i |=> eow_i); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(win_end_i)) |-> (acc_int_i >= $past(acc_int_i))); // R5
endmodule

bind act_mon_top act_mon_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run),
  .win_end_i(win_end),
  .irq_en_i (irq_en),
  .irq_i    (irq_o),
  .eow_i    (eow),
  .count_i  (count_val),
  .acc_int_i(acc_int)
);

// File: tb/act_mon_top_tb_top.sv
`timescale 1ns/1ps
module act_mon_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick_i = 1'b0;
  logic        busy_en_i = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  localparam logic [31:0] C_GLOB = 32'h8000_0000;
  localparam logic [31:0] C_IRQ  = 32'h0000_8000;
  localparam logic [31:0] C_PER  = 32'h0000_2000;
  localparam logic [31:0] S_EOW  = 32'h0800_0000;
  localparam int          LIM    = 70000;

  typedef struct packed {
    logic [31:0] w;
    logic [7:0]  per;
    logic [7:0]  n;
    logic [7:0]  r;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'd256,        8'd1, 8'd1, 8'd1},
    '{32'd256,        8'd2, 8'd4, 8'd1},
    '{32'd128,        8'd3, 8'd3, 8'd1},
    '{32'd1,          8'd1, 8'd1, 8'd1},
    '{32'd384,        8'd0, 8'd2, 8'd1},
    '{32'd256,        8'd1, 8'd1, 8'd3},
    '{32'hFFFF_FFFF,  8'd2, 8'd1, 8'd1},
    '{32'd200,        8'd5, 8'd7, 8'd2}
  };

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int base = 0;
  int busy_n = 1;
  int ref_r = 1;

  act_mon_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_tick_i(ref_tick_i), .busy_en_i(busy_en_i),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #2.5 clk_i = ~clk_i;

  // strobes for the cycle ending at edge E_j, j counted from the enabling write
  always @(posedge clk_i) begin
    #1;
    cyc = cyc + 1;
    busy_en_i = ((cyc - base) % busy_n) == 0;
    ref_tick_i = ((cyc - base) % ref_r) == 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    base = cyc;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  // returns negedges after the enabling write until irq_o is seen high
  task automatic wait_irq(output int k);
    k = 0;
    for (int i = 0; i < LIM; i++) begin
      @(negedge clk_i);
      k++;
      if (irq_o) break;
    end
  endtask

  function automatic logic [31:0] expect_cnt(input longint act, input longint w);
    longint v;
    v = (act * w) >>> 8;
    return (v > 64'h0000_0000_FFFF_FFFF) ? 32'hFFFF_FFFF : v[31:0];
  endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c0;
    int k, p, len;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h18, d); chk("R1 count", d, 32'h0);
    rd(8'h20, d); chk("R1 status", d, 32'h0);
    rd(8'h24, d); chk("R1 weight", d, 32'h100);
    rd(8'h28, d); chk("R1 tick", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // table of window vectors: R2 length, R3 count, R5 saturation
    for (int v = 0; v < NV; v++) begin
      wr(8'h00, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h24, VECS[v].w);
      wr(8'h28, 32'h0);
      busy_n = VECS[v].n;
      ref_r  = VECS[v].r;
      p   = (VECS[v].per == 0) ? 1 : int'(VECS[v].per);
      len = 256 * p * ref_r;
      wr(8'h00, C_GLOB | C_IRQ | C_PER | {24'b0, VECS[v].per});
      wait_irq(k);
      chk("R2 window length", k, len);
      rd(8'h18, d);
      chk((v == 6) ? "R5 saturated count" : "R3 weighted count", d,
          expect_cnt(longint'(len / busy_n), longint'(VECS[v].w)));
    end

    // R4 consecutive windows read the same count
    wr(8'h00, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'd256);
    busy_n = 1; ref_r = 1;
    wr(8'h00, C_GLOB | C_IRQ | C_PER | 32'd1);
    wait_irq(k);
    wr(8'h20, 32'h0);
    rd(8'h20, d); chk("R6 write zero keeps flag", d, S_EOW);
    wr(8'h20, S_EOW);
    chk("R6 W1C drops irq", {31'b0, irq_o}, 32'h0);
    wait_irq(k);
    rd(8'h18, d); chk("R4 second window count", d, 32'd256);

    // R7 masked: flag still sets, irq stays low, then level on unmask
    wr(8'h00, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h00, C_GLOB | C_PER | 32'd1);
    d = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (irq_o) d = 1;
    end
    chk("R7 masked irq low", d, 32'h0);
    rd(8'h20, d); chk("R6 flag set while masked", d, S_EOW);
    wr(8'h00, C_GLOB | C_IRQ | C_PER | 32'd1);
    chk("R7 irq level on unmask", {31'b0, irq_o}, 32'h1);
    repeat (3) @(negedge clk_i);
    chk("R7 irq stays high", {31'b0, irq_o}, 32'h1);

    // R8 global enable off: no further windows
    wr(8'h00, C_IRQ | C_PER | 32'd1);
    wr(8'h20, 32'hFFFF_FFFF);
    repeat (600) @(negedge clk_i);
    rd(8'h20, d); chk("R8 no window without global enable", d, 32'h0);
    // R8 periodic enable off
    wr(8'h00, C_GLOB | C_IRQ | 32'd1);
    repeat (600) @(negedge clk_i);
    rd(8'h20, d); chk("R8 no window without periodic enable", d, 32'h0);
    chk("R8 irq low", {31'b0, irq_o}, 32'h0);

    // R9 count not writable
    wr(8'h00, 32'h0);
    rd(8'h18, c0);
    wr(8'h18, 32'h1234_5678);
    rd(8'h18, d); chk("R9 count write ignored", d, c0);

    // R2 slow tick divisor
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h24, 32'd256);
    wr(8'h28, 32'h4);
    rd(8'h28, d); chk("R2 tick select readback", d, 32'h4);
    busy_n = 1; ref_r = 1;
    wr(8'h00, C_GLOB | C_IRQ | C_PER | 32'd1);
    wait_irq(k);
    chk("R2 slow window length", k, 65536);
    rd(8'h18, d); chk("R3 slow window count", d, 32'd65536);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule